// File: doc/BRIEF.md
# SDRAM Bank Auto-Precharge Tracker

This block follows a single SDRAM bank the way a memory controller sees it. It watches the decoded command stream and the bank address, and keeps the bank's state. It notices when a READ or WRITE asks for the bank to close itself after the burst. It then reports three things on its outputs: the cycle in which the bank's internal precharge begins, whether an ACTIVATE to the bank may be issued now, and whether the command presented in this cycle is one the bank must refuse because a self-closing burst is still running.

The tracker has four states, `IDLE`, `ACTIVE`, `BURST_AP` and `PRECHARGING`, with these transitions:

- `IDLE` to `ACTIVE`: on an ACTIVATE to this bank.
- `ACTIVE` to `BURST_AP`: on a READ or WRITE with the auto-close bit set, when the burst is longer than one word.
- `ACTIVE` to `PRECHARGING`: on the same kind of access with a one-word burst, or on an explicit PRECHARGE.
- `BURST_AP` to `PRECHARGING`: when the remaining burst count runs out.
- `PRECHARGING` to `IDLE`: when the recovery count (row precharge time after a read, data-in-to-activate time after a write) runs out.

One instance is placed per bank, and the parameter `MY_BANK` selects which bank an instance follows.

Top module: `apt_bank_tracker`

## Requirements
- R1: A synchronous active-low reset puts the bank in IDLE: act_ok=1, ap_start=0, illegal=0.
- R2: cmd=1 (ACTIVATE) with bank==MY_BANK while act_ok=1 opens the bank, so act_ok is 0 from the next cycle. A command whose bank differs from MY_BANK has no effect on any output.
- R3: On an open bank, cmd=2 (READ) or cmd=3 (WRITE) with a10=1 starts an auto-close access. With a10=0 the bank stays open, so the access can be cut short: cmd=5 (BURST STOP) and further reads or writes leave it open.
- R4: For a READ with auto-close issued in cycle T0 with burst length BL, ap_start is a one-cycle pulse in cycle T0+BL. That is one cycle before the last data word when cas_lat=2, and two cycles before it when cas_lat=3.
- R5: For a WRITE with auto-close issued in cycle T0, the last word is taken in T0+BL-1, and ap_start pulses in T0+BL.
- R6: After a READ with auto-close, act_ok returns to 1 in cycle T0+BL+TRP_CYC.
- R7: After a WRITE with auto-close, act_ok returns to 1 in cycle T0+BL+TDAL_CYC.
- R8: In cycles T0+1 to T0+BL-1 of an auto-close burst, a same-bank cmd of 2, 3, 4 or 5 raises illegal in the same cycle and is otherwise ignored. Any other command, or one to another bank, does not raise it.
- R9: bl_code selects the burst length: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8, and 4 to 7 give full page. In full-page mode a10 is ignored and the bank stays open.
- R10: cmd=4 (PRECHARGE) to an open bank in cycle T0 gives act_ok=1 again in T0+1+TRP_CYC, with no ap_start pulse.
- R11: An ACTIVATE presented while act_ok=0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd | input | 3 | Decoded command: 0 NOP, 1 ACTIVATE, 2 READ, 3 WRITE, 4 PRECHARGE, 5 BURST STOP, 6-7 NOP |
| a10 | input | 1 | Auto-close select for READ/WRITE |
| bank | input | BANK_W | Bank address of the command |
| cas_lat | input | 2 | CAS latency, 2 or 3 |
| bl_code | input | 3 | Burst length code (R9) |
| ap_start | output | 1 | Pulse in the cycle the internal precharge begins |
| act_ok | output | 1 | ACTIVATE to this bank allowed this cycle |
| illegal | output | 1 | Current command is forbidden during an auto-close burst |

## Verification
The bench aims at the cycle in which ap_start fires at both CAS latencies. A design that counted from the data position rather than from the command would pulse one cycle late at latency 3. It also checks the different recovery windows after reads and writes. Swapping the two parameters, or counting tDAL from the last word itself, moves the return of act_ok by one or more cycles.

The one-word and eight-word bursts test the counter's edge values; an off-by-one there skips or stretches BURST_AP. Commands that are forbidden, issued by a neighbour, or sent in full-page mode must leave every output untouched. A design that acted on them would close the bank early or flag illegal for another bank's traffic.

// File: rtl/apt_pkg.sv
package apt_pkg;

    typedef enum logic [2:0] {
        CMD_NOP   = 3'd0,
        CMD_ACT   = 3'd1,
        CMD_READ  = 3'd2,
        CMD_WRITE = 3'd3,
        CMD_PRE   = 3'd4,
        CMD_BST   = 3'd5
    } apt_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE        = 2'd0,
        ST_ACTIVE      = 2'd1,
        ST_BURST_AP    = 2'd2,
        ST_PRECHARGING = 2'd3
    } apt_state_e;

    // burst length in words for codes 0..3; full page otherwise
    function automatic int unsigned burst_words(input logic [2:0] code);
        case (code)
            3'd0:    return 1;
            3'd1:    return 2;
            3'd2:    return 4;
            3'd3:    return 8;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/apt_cmd_decode.sv
module apt_cmd_decode
    import apt_pkg::*;
#(
    parameter int BANK_W  = 2,
    parameter int MY_BANK = 0
) (
    input  logic [2:0]        cmd,
    input  logic              a10,
    input  logic [BANK_W-1:0] bank,
    input  logic              full_page,
    output logic              act_hit,
    output logic              pre_hit,
    output logic              ap_hit,
    output logic              ap_is_wr,
    output logic              lock_hit
);
    localparam logic [BANK_W-1:0] MY_ADDR = BANK_W'(MY_BANK);

    logic mine;
    logic rw;

    always_comb begin
        mine     = (bank == MY_ADDR);
        rw       = (cmd == CMD_READ) || (cmd == CMD_WRITE);
        act_hit  = mine && (cmd == CMD_ACT);
        pre_hit  = mine && (cmd == CMD_PRE);
        ap_hit   = mine && rw && a10 && !full_page;
        ap_is_wr = (cmd == CMD_WRITE);
        lock_hit = mine && (rw || (cmd == CMD_PRE) || (cmd == CMD_BST));
    end

endmodule

// File: rtl/apt_timing.sv
module apt_timing
    import apt_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic [2:0]       bl_code,
    input  logic [1:0]       cas_lat,
    input  logic             is_wr,
    output logic             full_page,
    output logic [CNT_W-1:0] burst_cyc
);
    int unsigned bl;
    int unsigned last_word;
    int unsigned lead;

    always_comb begin
        bl        = burst_words(bl_code);
        full_page = (bl == 0);
        if (is_wr) begin
            // write: precharge begins the clock after the last word (T0+BL-1)
            last_word = (bl == 0) ? 0 : bl - 1;
            lead      = 0;
            burst_cyc = CNT_W'(last_word + 1);
        end else begin
            // read: last word at T0+CL+BL-1, precharge leads it by CL-1
            last_word = 32'(cas_lat) + bl - 1;
            lead      = 32'(cas_lat) - 1;
            burst_cyc = CNT_W'(last_word - lead);
        end
    end

endmodule

// File: rtl/apt_bank_tracker.sv
module apt_bank_tracker
    import apt_pkg::*;
#(
    parameter int BANK_W   = 2,
    parameter int MY_BANK  = 0,
    parameter int TRP_CYC  = 3,
    parameter int TDAL_CYC = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cmd,
    input  logic              a10,
    input  logic [BANK_W-1:0] bank,
    input  logic [1:0]        cas_lat,
    input  logic [2:0]        bl_code,
    output logic              ap_start,
    output logic              act_ok,
    output logic              illegal
);
    localparam int MAX_CYC = (TRP_CYC > TDAL_CYC) ?
                             ((TRP_CYC > 12) ? TRP_CYC : 12) :
                             ((TDAL_CYC > 12) ? TDAL_CYC : 12);
    localparam int CNT_W = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] TRP_L  = CNT_W'(TRP_CYC);
    localparam logic [CNT_W-1:0] TDAL_L = CNT_W'(TDAL_CYC);
    localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);

    apt_state_e       state, state_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic             fresh, fresh_n;
    logic             wr_kind, wr_kind_n;

    logic             act_hit, pre_hit, ap_hit, ap_is_wr, lock_hit;
    logic             full_page;
    logic [CNT_W-1:0] burst_cyc;

    apt_cmd_decode #(.BANK_W(BANK_W), .MY_BANK(MY_BANK)) u_dec (
        .cmd      (cmd),
        .a10      (a10),
        .bank     (bank),
        .full_page(full_page),
        .act_hit  (act_hit),
        .pre_hit  (pre_hit),
        .ap_hit   (ap_hit),
        .ap_is_wr (ap_is_wr),
        .lock_hit (lock_hit)
    );

    apt_timing #(.CNT_W(CNT_W)) u_tim (
        .bl_code  (bl_code),
        .cas_lat  (cas_lat),
        .is_wr    (ap_is_wr),
        .full_page(full_page),
        .burst_cyc(burst_cyc)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            fresh   <= 1'b0;
            wr_kind <= 1'b0;
        end else begin
            state   <= state_n;
            cnt     <= cnt_n;
            fresh   <= fresh_n;
            wr_kind <= wr_kind_n;
        end
    end

    // next state
    always_comb begin
        state_n   = state;
        cnt_n     = cnt;
        fresh_n   = 1'b0;
        wr_kind_n = wr_kind;
        unique case (state)
            ST_IDLE: begin
                if (act_hit) state_n = ST_ACTIVE;
            end
            ST_ACTIVE: begin
                if (ap_hit) begin
                    wr_kind_n = ap_is_wr;
                    if (burst_cyc == ONE) begin
                        state_n = ST_PRECHARGING;
                        cnt_n   = ap_is_wr ? TDAL_L : TRP_L;
                        fresh_n = 1'b1;
                    end else begin
                        state_n = ST_BURST_AP;
                        cnt_n   = burst_cyc - ONE;
                    end
                end else if (pre_hit) begin
                    state_n = ST_PRECHARGING;
                    cnt_n   = TRP_L;
                end
            end
            ST_BURST_AP: begin
                if (cnt == ONE) begin
                    state_n = ST_PRECHARGING;
                    cnt_n   = wr_kind ? TDAL_L : TRP_L;
                    fresh_n = 1'b1;
                end else begin
                    cnt_n = cnt - ONE;
                end
            end
            ST_PRECHARGING: begin
                if (cnt == ONE) state_n = ST_IDLE;
                else            cnt_n   = cnt - ONE;
            end
        endcase
    end

    // outputs
    always_comb begin
        ap_start = (state == ST_PRECHARGING) && fresh;
        act_ok   = (state == ST_IDLE);
        illegal  = (state == ST_BURST_AP) && lock_hit;
    end

endmodule

// File: rtl/apt_checker.sv
module apt_checker #(
    parameter int BANK_W  = 2,
    parameter int MY_BANK = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        cmd,
    input logic [BANK_W-1:0] bank,
    input logic              ap_start,
    input logic              act_ok,
    input logic              illegal
);
    // R1: reset leaves the bank idle
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (act_ok && !ap_start && !illegal));

    // R2: the bank leaves idle only through an own-bank ACTIVATE
    assert_open_by_act_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(act_ok) |-> $past(cmd == 3'd1 && bank == BANK_W'(MY_BANK)));

    // R4: precharge start is a single-cycle pulse
    assert_ap_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ap_start |=> !ap_start);

    // R6: activate is never allowed in the cycle precharge begins
    assert_no_act_at_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ap_start |-> !act_ok);

    // R8: illegal only while the bank is busy with a burst
    assert_illegal_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!act_ok && !ap_start));

endmodule

bind apt_bank_tracker apt_checker #(.BANK_W(BANK_W), .MY_BANK(MY_BANK)) u_apt_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd     (cmd),
    .bank    (bank),
    .ap_start(ap_start),
    .act_ok  (act_ok),
    .illegal (illegal)
);

// File: tb/apt_bank_tracker_bench.sv
module apt_bank_tracker_bench;
    localparam int CLK_PERIOD = 10;
    localparam int BANK_W = 2;
    localparam int MYB    = 1;
    localparam int TRP    = 3;
    localparam int TDAL   = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [2:0]        cmd = 3'd0;
    logic              a10 = 1'b0;
    logic [BANK_W-1:0] bank = '0;
    logic [1:0]        cas_lat = 2'd2;
    logic [2:0]        bl_code = 3'd2;
    logic              ap_start, act_ok, illegal;

    int checks = 0;
    int errors = 0;

    // reference model state
    int cyc = 0;
    bit m_open = 0;
    int m_free = 0;
    int m_ap = -100;
    int m_issue = -100;

    always #(CLK_PERIOD/2) clk = ~clk;

    apt_bank_tracker #(.BANK_W(BANK_W), .MY_BANK(MYB), .TRP_CYC(TRP), .TDAL_CYC(TDAL))
    u_apt_bank_tracker (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .a10(a10), .bank(bank),
        .cas_lat(cas_lat), .bl_code(bl_code),
        .ap_start(ap_start), .act_ok(act_ok), .illegal(illegal)
    );

    function automatic int bl_of(input logic [2:0] c);
        case (c)
            3'd0: return 1;
            3'd1: return 2;
            3'd2: return 4;
            3'd3: return 8;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s cycle %0d actual %0b expected %0b", req, cyc, act, exp);
        end
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // one cycle: drive, compare against model, advance model
    task automatic step(input logic [2:0] c, input logic a, input int b);
        bit mine;
        bit e_ap, e_ok, e_ill;
        int bl;
        @(negedge clk);
        cmd = c; a10 = a; bank = BANK_W'(b);
        #1;
        mine = (b == MYB);
        bl = bl_of(bl_code);
        if (rst_n) begin
            e_ap  = (cyc == m_ap);
            e_ok  = !m_open && (cyc >= m_free);
            e_ill = (cyc > m_issue) && (cyc < m_ap) && mine &&
                    (c == 3'd2 || c == 3'd3 || c == 3'd4 || c == 3'd5);
            chk("R4/R5 ap_start", ap_start, e_ap);
            chk("R6/R7 act_ok", act_ok, e_ok);
            chk("R8 illegal", illegal, e_ill);
            if (e_ok && mine && c == 3'd1) begin
                m_open = 1;                           // R2
            end else if (m_open && mine) begin
                if ((c == 3'd2 || c == 3'd3) && a && bl != 0) begin
                    m_open  = 0;                      // R3
                    m_issue = cyc;
                    m_ap    = cyc + bl;
                    m_free  = m_ap + ((c == 3'd3) ? TDAL : TRP);
                end else if (c == 3'd4) begin
                    m_open = 0;                       // R10
                    m_free = cyc + 1 + TRP;
                end
            end
        end else begin
            m_open = 0; m_free = cyc + 1; m_ap = -100; m_issue = -100;
        end
        cyc++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(3'd0, 1'b0, MYB);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        // R1 reset
        rst_n = 0;
        idle(2);
        rst_n = 1;
        idle(2);

        // R2 R4 R6 R8: read auto-close, BL4, CL2, with forbidden commands
        bl_code = 3'd2; cas_lat = 2'd2;
        step(3'd1, 0, 0);           // other bank ACT: no effect (R2)
        step(3'd1, 0, MYB);
        step(3'd2, 1, MYB);
        step(3'd2, 0, 0);           // other bank read: not illegal
        step(3'd2, 0, MYB);         // illegal (R8)
        step(3'd5, 0, MYB);         // illegal BST
        idle(1);
        step(3'd1, 0, MYB);         // ACT while precharging ignored (R11)
        idle(5);

        // R4 CL3: start cycle unchanged
        cas_lat = 2'd3;
        step(3'd1, 0, MYB);
        step(3'd2, 1, MYB);
        step(3'd3, 0, MYB);         // illegal write
        step(3'd4, 0, MYB);         // illegal precharge
        idle(8);

        // R5 R7 write auto-close BL4
        cas_lat = 2'd2;
        step(3'd1, 0, MYB);
        step(3'd3, 1, MYB);
        idle(12);

        // R3 R10 plain read interrupted, then explicit precharge
        step(3'd1, 0, MYB);
        step(3'd2, 0, MYB);
        step(3'd5, 0, MYB);
        step(3'd3, 0, MYB);
        idle(2);
        step(3'd4, 0, MYB);
        idle(6);

        // R9 full page: a10 ignored
        bl_code = 3'd7;
        step(3'd1, 0, MYB);
        step(3'd2, 1, MYB);
        step(3'd3, 1, MYB);
        idle(10);
        step(3'd4, 0, MYB);
        idle(6);

        // R9 boundary burst lengths: BL8 write, BL1 read, BL2 read
        bl_code = 3'd3;
        step(3'd1, 0, MYB);
        step(3'd3, 1, MYB);
        step(3'd2, 0, MYB);
        idle(16);
        bl_code = 3'd0;
        step(3'd1, 0, MYB);
        step(3'd2, 1, MYB);
        idle(6);
        bl_code = 3'd1; cas_lat = 2'd3;
        step(3'd1, 0, MYB);
        step(3'd2, 1, MYB);
        step(3'd2, 1, MYB);         // illegal
        idle(6);

        // R1 reset in mid-burst
        bl_code = 3'd3;
        step(3'd1, 0, MYB);
        step(3'd3, 1, MYB);
        idle(2);
        rst_n = 0;
        idle(1);
        rst_n = 1;
        idle(3);

        summary();
    end

endmodule